// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block works out where the program counter goes after a control-transfer instruction. Each cycle it takes the current PC, the instruction's offset field, one integer register operand, the floating-point compare flag and a decoded operation code. One clock later it presents the next PC, a flag saying whether control left the sequential path, and, for the linking jumps, a write enable and the return address destined for register 31.

The block handles six kinds of transfer. Two branches test an integer register against zero: one taken when the register is zero, one when it is nonzero. Two branches test the floating-point compare flag: one taken when the flag is set, one when it is clear. A jump can add a long offset to the PC, or it can take its target from a register. Each jump form also has a linking variant that records the return address. Branches and offset jumps measure their displacement from the address of the following instruction. The return address points two instructions past the current one.

The block has one register stage on its outputs. Its asynchronous active-low reset is released in step with the clock through a short synchronizer.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `npc_o`, `taken_o`, `link_we_o` and `link_val_o` are all zero.
- R2: The outputs in a cycle are computed from the inputs sampled at the preceding rising clock edge, so the latency is exactly one cycle.
- R3: Op code 1 (branch on zero) is taken when all 32 bits of `reg_val_i` are zero. Its target is `pc_i + 4` plus `offs_i[15:0]` sign-extended from bit 15.
- R4: Op code 2 (branch on nonzero) is taken when any bit of `reg_val_i` is set. Its target is the same as in R3.
- R5: Op code 3 (branch on flag true) is taken when `fp_flag_i` is 1. Op code 4 (branch on flag false) is taken when `fp_flag_i` is 0. Both use the target defined in R3.
- R6: Op code 5 (offset jump) is always taken. Its target is `pc_i + 4` plus `offs_i[25:0]` sign-extended from bit 25.
- R7: Op code 6 (register jump) is always taken. Its target is `reg_val_i` exactly as given.
- R8: Op code 7 (linking offset jump) moves the PC as in R6, and op code 8 (linking register jump) moves it as in R7. Both assert `link_we_o` and present `pc_i + 8` on `link_val_o`.
- R9: A branch that is not taken, op code 0, and the unused codes 9 to 15 all give `taken_o` = 0 and `npc_o` = `pc_i + 4`.
- R10: For every op code except 7 and 8, `link_we_o` is 0 and `link_val_o` is 0.
- R11: Branches ignore `offs_i[25:16]`, and no operation other than 1 to 4 is affected by `reg_val_i` unless it is a register jump.
- R12: All address sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_i | input | 32 | PC of the current instruction |
| offs_i | input | 26 | Offset field; branches use bits 15:0, jumps use all 26 bits |
| reg_val_i | input | 32 | Integer register operand: tested value or jump target |
| fp_flag_i | input | 1 | Floating-point compare flag |
| op_i | input | 4 | Control operation code (0 none, 1 to 8 as in R3 to R8) |
| npc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Control left the sequential path |
| link_we_o | output | 1 | Write the return address to register 31 |
| link_val_o | output | 32 | Return address (PC+8) for register 31 |

## Verification
Each branch is driven with its condition both true and false. This separates a correct condition from an inverted one or one stuck at a constant. Register tests use values with a single high bit set, which exposes a zero test that looks at only part of the word. Offsets are tried positive and negative, with junk in bits 25:16 for branches, which shows whether the sign is taken from the right bit and whether the branch field is kept separate from the jump field. Register jumps with a register that is also zero or nonzero, unused op codes, and PCs near the top of the address space check the R11 and R12 cases. A long stream of random operations then catches interactions from one cycle to the next.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    CT_NONE = 4'd0,
    CT_BEQZ = 4'd1,
    CT_BNEZ = 4'd2,
    CT_BFPT = 4'd3,
    CT_BFPF = 4'd4,
    CT_J    = 4'd5,
    CT_JR   = 4'd6,
    CT_JAL  = 4'd7,
    CT_JALR = 4'd8
  } ctl_op_e;

  // Source selected for the next PC
  typedef enum logic [1:0] {
    SEL_SEQ  = 2'd0,
    SEL_BR   = 2'd1,
    SEL_JOFF = 2'd2,
    SEL_REG  = 2'd3
  } npc_sel_e;

endpackage

// File: rtl/npc_rst_sync.sv
module npc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/npc_cond_eval.sv
module npc_cond_eval
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] reg_val,
  input  logic            fp_flag,
  output logic            taken,
  output logic            link,
  output npc_sel_e        sel
);

  logic reg_is_zero;

  assign reg_is_zero = (reg_val == '0);

  always_comb begin
    taken = 1'b0;
    link  = 1'b0;
    sel   = SEL_SEQ;
    case (op)
      CT_BEQZ: taken = reg_is_zero;
      CT_BNEZ: taken = !reg_is_zero;
      CT_BFPT: taken = fp_flag;
      CT_BFPF: taken = !fp_flag;
      CT_J: begin
        taken = 1'b1;
        sel   = SEL_JOFF;
      end
      CT_JR: begin
        taken = 1'b1;
        sel   = SEL_REG;
      end
      CT_JAL: begin
        taken = 1'b1;
        link  = 1'b1;
        sel   = SEL_JOFF;
      end
      CT_JALR: begin
        taken = 1'b1;
        link  = 1'b1;
        sel   = SEL_REG;
      end
      default: begin
        taken = 1'b0;
      end
    endcase
    // conditional branches pick the short-offset target only when taken
    if (taken && (op == CT_BEQZ || op == CT_BNEZ ||
                  op == CT_BFPT || op == CT_BFPF)) begin
      sel = SEL_BR;
    end
  end

endmodule

// File: rtl/npc_target_gen.sv
module npc_target_gen
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int BR_OFF_W = 16,
  parameter int J_OFF_W  = 26
) (
  input  logic [XLEN-1:0]    pc,
  input  logic [J_OFF_W-1:0] offs,
  input  logic [XLEN-1:0]    reg_val,
  input  npc_sel_e           sel,
  input  logic               link,
  output logic [XLEN-1:0]    npc,
  output logic [XLEN-1:0]    link_val
);

  localparam logic [XLEN-1:0] STEP1 = XLEN'(4);
  localparam logic [XLEN-1:0] STEP2 = XLEN'(8);

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] ret_pc;
  logic [XLEN-1:0] br_ext;
  logic [XLEN-1:0] j_ext;
  logic [XLEN-1:0] br_tgt;
  logic [XLEN-1:0] j_tgt;

  // sign extension for the short and long displacement fields
  generate
    if (XLEN > BR_OFF_W) begin : g_br_ext
      assign br_ext = {{(XLEN-BR_OFF_W){offs[BR_OFF_W-1]}}, offs[BR_OFF_W-1:0]};
    end else begin : g_br_trunc
      assign br_ext = offs[XLEN-1:0];
    end
    if (XLEN > J_OFF_W) begin : g_j_ext
      assign j_ext = {{(XLEN-J_OFF_W){offs[J_OFF_W-1]}}, offs};
    end else begin : g_j_trunc
      assign j_ext = offs[XLEN-1:0];
    end
  endgenerate

  assign seq_pc = pc + STEP1;
  assign ret_pc = pc + STEP2;
  assign br_tgt = seq_pc + br_ext;
  assign j_tgt  = seq_pc + j_ext;

  always_comb begin
    case (sel)
      SEL_BR:   npc = br_tgt;
      SEL_JOFF: npc = j_tgt;
      SEL_REG:  npc = reg_val;
      default:  npc = seq_pc;
    endcase
    link_val = link ? ret_pc : '0;
  end

endmodule

// File: rtl/npc_out_reg.sv
module npc_out_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_sync_n,
  input  logic [XLEN-1:0] npc_d,
  input  logic            taken_d,
  input  logic            link_d,
  input  logic [XLEN-1:0] link_val_d,
  output logic [XLEN-1:0] npc_q,
  output logic            taken_q,
  output logic            link_q,
  output logic [XLEN-1:0] link_val_q
);

  logic [XLEN-1:0] npc_nxt;
  logic            taken_nxt;
  logic            link_nxt;
  logic [XLEN-1:0] link_val_nxt;

  always_comb begin
    npc_nxt      = npc_d;
    taken_nxt    = taken_d;
    link_nxt     = link_d;
    link_val_nxt = link_val_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      npc_q      <= '0;
      taken_q    <= 1'b0;
      link_q     <= 1'b0;
      link_val_q <= '0;
    end else begin
      npc_q      <= npc_nxt;
      taken_q    <= taken_nxt;
      link_q     <= link_nxt;
      link_val_q <= link_val_nxt;
    end
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int BR_OFF_W   = 16,
  parameter int J_OFF_W    = 26,
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [J_OFF_W-1:0] offs_i,
  input  logic [XLEN-1:0]    reg_val_i,
  input  logic               fp_flag_i,
  input  logic [OP_W-1:0]    op_i,
  output logic [XLEN-1:0]    npc_o,
  output logic               taken_o,
  output logic               link_we_o,
  output logic [XLEN-1:0]    link_val_o
);

  logic            rst_sync_n;
  logic            taken_c;
  logic            link_c;
  npc_sel_e        sel_c;
  logic [XLEN-1:0] npc_c;
  logic [XLEN-1:0] link_val_c;

  npc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  npc_cond_eval #(.XLEN(XLEN)) u_cond (
    .op      (op_i),
    .reg_val (reg_val_i),
    .fp_flag (fp_flag_i),
    .taken   (taken_c),
    .link    (link_c),
    .sel     (sel_c)
  );

  npc_target_gen #(
    .XLEN     (XLEN),
    .BR_OFF_W (BR_OFF_W),
    .J_OFF_W  (J_OFF_W)
  ) u_tgt (
    .pc       (pc_i),
    .offs     (offs_i),
    .reg_val  (reg_val_i),
    .sel      (sel_c),
    .link     (link_c),
    .npc      (npc_c),
    .link_val (link_val_c)
  );

  npc_out_reg #(.XLEN(XLEN)) u_oreg (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .npc_d      (npc_c),
    .taken_d    (taken_c),
    .link_d     (link_c),
    .link_val_d (link_val_c),
    .npc_q      (npc_o),
    .taken_q    (taken_o),
    .link_q     (link_we_o),
    .link_val_q (link_val_o)
  );

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rst_sync_n,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] reg_val_i,
  input logic [3:0]      op_i,
  input logic [XLEN-1:0] npc_o,
  input logic            taken_o,
  input logic            link_we_o,
  input logic [XLEN-1:0] link_val_o
);

  logic armed;

  // set one edge after the synchronized reset lifts, when outputs first carry data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
    end else if (rst_sync_n) begin
      armed <= 1'b1;
    end
  end

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_zero_chk: assert (npc_o == '0 && !taken_o && !link_we_o && link_val_o == '0);
    end
  end

  // R7
  reg_jump_chk: assert property (@(posedge clk) disable iff (!armed)
    ($past(op_i) == 4'd6) |-> (taken_o && npc_o == $past(reg_val_i)));

  // R8
  link_value_chk: assert property (@(posedge clk) disable iff (!armed)
    link_we_o |-> (link_val_o == $past(pc_i) + XLEN'(8)));

  // R9
  seq_path_chk: assert property (@(posedge clk) disable iff (!armed)
    !taken_o |-> (npc_o == $past(pc_i) + XLEN'(4)));

  // R10
  link_only_chk: assert property (@(posedge clk) disable iff (!armed)
    link_we_o |-> ($past(op_i) == 4'd7 || $past(op_i) == 4'd8));

  // R10
  link_idle_chk: assert property (@(posedge clk) disable iff (!armed)
    !link_we_o |-> (link_val_o == '0));

endmodule

bind npc_unit npc_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .pc_i       (pc_i),
  .reg_val_i  (reg_val_i),
  .op_i       (op_i),
  .npc_o      (npc_o),
  .taken_o    (taken_o),
  .link_we_o  (link_we_o),
  .link_val_o (link_val_o)
);

// File: tb/npc_unit_test.sv
`timescale 1ns/1ps
module npc_unit_test;

  logic        clk;
  logic        rst_n;
  logic [31:0] pc_i;
  logic [25:0] offs_i;
  logic [31:0] reg_val_i;
  logic        fp_flag_i;
  logic [3:0]  op_i;
  logic [31:0] npc_o;
  logic        taken_o;
  logic        link_we_o;
  logic [31:0] link_val_o;

  int checks = 0;
  int fails  = 0;

  // pending expectation for the next compare
  logic        have_exp = 1'b0;
  logic [31:0] e_npc;
  logic        e_tk;
  logic        e_lw;
  logic [31:0] e_lv;
  string       e_tag;

  npc_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_i       (pc_i),
    .offs_i     (offs_i),
    .reg_val_i  (reg_val_i),
    .fp_flag_i  (fp_flag_i),
    .op_i       (op_i),
    .npc_o      (npc_o),
    .taken_o    (taken_o),
    .link_we_o  (link_we_o),
    .link_val_o (link_val_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference taken from the requirements
  task automatic ref_model(input int op, input logic [31:0] pc, input logic [25:0] off,
                           input logic [31:0] rv, input bit fp,
                           output logic [31:0] npc, output logic tk,
                           output logic lw, output logic [31:0] lv);
    longint unsigned nxt;
    longint signed   sb;
    longint signed   sj;
    bit cond;
    nxt = (longint'(pc) + 4) % (64'd1 << 32);
    sb  = longint'($signed(off[15:0]));
    sj  = longint'($signed(off));
    npc = nxt[31:0];
    tk  = 0; lw = 0; lv = 0;
    cond = 0;
    case (op)
      1: cond = (rv == 0);
      2: cond = (rv != 0);
      3: cond = fp;
      4: cond = !fp;
      default: cond = 0;
    endcase
    if (op >= 1 && op <= 4 && cond) begin
      tk = 1; npc = 32'(longint'(nxt) + sb);
    end
    if (op == 5 || op == 7) begin
      tk = 1; npc = 32'(longint'(nxt) + sj);
    end
    if (op == 6 || op == 8) begin
      tk = 1; npc = rv;
    end
    if (op == 7 || op == 8) begin
      lw = 1; lv = 32'(longint'(pc) + 8);
    end
  endtask

  task automatic compare();
    checks++;
    if (npc_o !== e_npc || taken_o !== e_tk || link_we_o !== e_lw || link_val_o !== e_lv) begin
      fails++;
      $display("FAIL %s: npc=%h taken=%b lwe=%b lval=%h expected npc=%h taken=%b lwe=%b lval=%h",
               e_tag, npc_o, taken_o, link_we_o, link_val_o, e_npc, e_tk, e_lw, e_lv);
    end
  endtask

  // one cycle: check outputs from last inputs (R2), then apply new inputs
  task automatic step(input int op, input logic [31:0] pc, input logic [25:0] off,
                      input logic [31:0] rv, input bit fp, input string tag);
    @(negedge clk);
    if (have_exp) compare();
    op_i = op[3:0]; pc_i = pc; offs_i = off; reg_val_i = rv; fp_flag_i = fp;
    ref_model(op, pc, off, rv, fp, e_npc, e_tk, e_lw, e_lv);
    e_tag = tag;
    have_exp = 1'b1;
  endtask

  initial begin
    #800000;
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    op_i = 0; pc_i = 32'h1000; offs_i = 0; reg_val_i = 0; fp_flag_i = 0;
    repeat (3) @(negedge clk);
    // R1: drive a jump while in reset, outputs must stay zero
    op_i = 4'd7; reg_val_i = 32'h55;
    repeat (2) @(negedge clk);
    checks++;
    if (npc_o !== 0 || taken_o !== 0 || link_we_o !== 0 || link_val_o !== 0) begin
      fails++;
      $display("FAIL R1: npc=%h taken=%b lwe=%b lval=%h expected all zero",
               npc_o, taken_o, link_we_o, link_val_o);
    end
    op_i = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    step(1, 32'h0000_1000, 26'h0000_010, 32'h0,         0, "R3 beqz zero taken");
    step(1, 32'h0000_1000, 26'h0000_010, 32'h8000_0000, 0, "R3 beqz top bit not taken");
    step(1, 32'h0000_2000, 26'h3FF_FFF0, 32'h0,         0, "R3 R11 beqz neg off junk upper");
    step(1, 32'h0000_2000, 26'h155_7FFC, 32'h0,         1, "R11 beqz upper field ignored");
    step(2, 32'h0000_3000, 26'h0000_020, 32'h0000_0001, 0, "R4 bnez low bit taken");
    step(2, 32'h0000_3000, 26'h0000_020, 32'h0,         1, "R4 bnez zero not taken");
    step(3, 32'h0000_4000, 26'h0000_0FC, 32'h0,         1, "R5 bfpt set");
    step(3, 32'h0000_4000, 26'h0000_0FC, 32'h0,         0, "R5 bfpt clear");
    step(4, 32'h0000_4000, 26'h000_8000, 32'h1,         0, "R5 bfpf clear taken neg");
    step(4, 32'h0000_4000, 26'h000_8000, 32'h1,         1, "R5 bfpf set");
    step(5, 32'h0010_0000, 26'h000_1234, 32'h0,         0, "R6 j positive");
    step(5, 32'h0010_0000, 26'h200_0000, 32'hFFFF_FFFF, 1, "R6 j most negative");
    step(6, 32'h0010_0000, 26'h000_1234, 32'hDEAD_BEE0, 0, "R7 jr");
    step(6, 32'h0010_0000, 26'h000_1234, 32'h0,         0, "R7 jr zero reg");
    step(7, 32'h0020_0000, 26'h3FF_FF00, 32'h1,         0, "R8 jal");
    step(8, 32'h0020_0000, 26'h000_0040, 32'h0040_0000, 1, "R8 jalr");
    step(0, 32'h0030_0000, 26'h3FF_FFFF, 32'h0,         1, "R9 R10 none");
    step(9, 32'h0030_0000, 26'h123_4567, 32'h0,         0, "R9 R10 unused op 9");
    step(15,32'h0030_0000, 26'h123_4567, 32'h1,         1, "R9 R10 unused op 15");
    step(0, 32'hFFFF_FFFC, 26'h0,        32'h0,         0, "R12 seq wrap");
    step(8, 32'hFFFF_FFF8, 26'h0,        32'h7,         0, "R12 R8 link wrap");
    step(5, 32'hFFFF_FFF0, 26'h000_0100, 32'h0,         0, "R12 j wrap");

    for (int i = 0; i < 400; i++) begin
      step(int'($urandom_range(0, 15)), $urandom, 26'($urandom),
           ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom, 1'($urandom),
           "R2 random stream");
    end
    @(negedge clk);
    compare();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule